// File: doc/BRIEF.md
# Configuration Stream Watermark Inserter

This block sits on a stream of logic-block configuration records and hides a signature in control bits that have no functional effect. Each record describes one logic block with four outputs: two combinational ones and two registered ones. An output whose pin does not reach external interconnect is marked unused. The selector bits of the multiplexers that drive an unused output can then hold any value without changing the circuit.

In embed mode, those selector bits are overwritten with bits taken one at a time from a serial watermark source. In extract mode, the block walks the same fields in the same order and emits their current values as a serial bit stream, so a marked configuration gives back its signature unchanged.

Records enter and leave through valid/ready handshakes. The watermark source has its own valid/ready pair and a last-bit marker. A counter reports how many bits have been embedded or extracted since reset.

Top module: `wm_cfg_marker`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid`, `ext_valid` and `wm_done` are 0, and `bit_count` is 0.
- R2: Record layout and pass-through.
  - `in_used` bit 0 is combinational output A, bit 1 is combinational output B, bit 2 is registered output C, and bit 3 is registered output D. A 1 means the output is connected.
  - `in_ctl` bit 0 selects for A and bit 1 selects for B. Bits 2..4 are the three 2:1 selects of C, and bits 6:5 are its 4:1 select (bit 6 is the MSB). Bits 7..9 are the three 2:1 selects of D, and bits 11:10 are its 4:1 select (bit 11 is the MSB).
  - Payload, usage flags and the control bits of connected outputs leave unchanged.
- R3: An unused combinational output takes 1 watermark bit, an unused registered output takes 5 bits, and a record with all four outputs unused takes 12 bits.
- R4: Within a record, outputs are filled in the order A, B, C, D. For a registered output, the three 2:1 selects are filled in ascending bit order, then the 4:1 select MSB, then its LSB. Watermark bits are consumed in arrival order, continuing across records in stream order.
- R5: While an unused field is waiting for a watermark bit that has not arrived, the record is held: `out_valid` stays 0 and `in_ready` stays 0 until the bit comes.
- R6: End of watermark.
  - Once the bit flagged with `wm_last` has been embedded, `wm_done` becomes 1 and `wm_ready` stays 0.
  - Every later unused field passes through unchanged.
- R7: In extract mode (`mode_extract`=1), each unused field in R4 order produces one `ext_valid` pulse whose `ext_bit` is that control bit. The record leaves unchanged and `wm_ready` stays 0.
- R8: `bit_count` rises by exactly one for each bit embedded or extracted, and by at most one per cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output record holds steady. `in_ready` and `out_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_extract | input | 1 | 0 embeds, 1 extracts; change only while in reset |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Block can take a record |
| in_payload | input | PAYLOAD_W | Other configuration bits, passed through |
| in_used | input | 4 | Connection flags of the four outputs |
| in_ctl | input | 12 | Multiplexer select bits of the four outputs |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream takes the record |
| out_payload | output | PAYLOAD_W | Payload out |
| out_used | output | 4 | Connection flags out |
| out_ctl | output | 12 | Select bits out, marked in embed mode |
| wm_valid | input | 1 | Watermark bit available |
| wm_ready | output | 1 | Watermark bit taken this cycle |
| wm_bit | input | 1 | Watermark bit value |
| wm_last | input | 1 | Marks the final watermark bit |
| ext_valid | output | 1 | One-cycle pulse per extracted bit |
| ext_bit | output | 1 | Extracted bit value |
| bit_count | output | COUNT_W | Bits embedded or extracted since reset |
| wm_done | output | 1 | Last watermark bit has been embedded |

## Verification
The bench sweeps all sixteen usage patterns, each with a distinct select pattern, and compares every output field with a bench-side model of the fill order.

- A design that swapped the two bits of a 4:1 select, or filled registered outputs in the wrong order, would corrupt exactly those records.
- Feeding the marked records back in extract mode must return the original bit stream. Any asymmetry between the embed and extract paths would scramble the recovered signature.
- A short watermark that ends partway through a registered output checks that the remaining fields stay untouched. A design that kept writing, or that took one extra bit, would alter them.
- A stalled bit source and a throttled downstream check that a record is neither released early nor changed while it waits.

// File: rtl/wm_pkg.sv
package wm_pkg;

  localparam int NUM_OUT  = 4;
  localparam int NUM_SLOT = 12;
  localparam int SLOT_W   = $clog2(NUM_SLOT);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_SEND
  } scan_state_t;

  // output that owns fill slot k (A, B, C, D = 0..3)
  function automatic int owner_of(input int k);
    if (k < 2) return k;
    else if (k < 7) return 2;
    else return 3;
  endfunction

  // control bit position written by fill slot k
  function automatic int pos_of(input int k);
    int base;
    int j;
    if (k < 2) return k;
    base = (k < 7) ? 2 : 7;
    j = k - base;
    if (j < 3) return base + j;
    else if (j == 3) return base + 4;
    else return base + 3;
  endfunction

endpackage

// File: rtl/wm_slot_decode.sv
module wm_slot_decode
  import wm_pkg::*;
(
  input  logic [NUM_OUT-1:0] used,
  input  logic [SLOT_W-1:0]  slot,
  output logic               slot_open,
  output logic [SLOT_W-1:0]  slot_pos
);

  logic [NUM_SLOT-1:0] open_tab;
  logic [SLOT_W-1:0]   pos_tab [NUM_SLOT];

  generate
    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
      localparam int OWNER = owner_of(g);
      localparam int POS   = pos_of(g);
      assign open_tab[g] = ~used[OWNER];
      assign pos_tab[g]  = SLOT_W'(POS);
    end
  endgenerate

  always_comb begin
    slot_open = 1'b0;
    slot_pos  = '0;
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (slot == SLOT_W'(i)) begin
        slot_open = open_tab[i];
        slot_pos  = pos_tab[i];
      end
    end
  end

endmodule

// File: rtl/wm_scan_ctrl.sv
module wm_scan_ctrl
  import wm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              out_ready,
  input  logic              slot_open,
  input  logic              mode_extract,
  input  logic              done,
  input  logic              wm_valid,
  output logic [SLOT_W-1:0] slot,
  output logic              in_ready,
  output logic              out_valid,
  output logic              wm_ready,
  output logic              take_bit,
  output logic              read_bit,
  output logic              load
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOT - 1);

  scan_state_t state;
  logic scanning;
  logic need_bit;
  logic advance;

  always_comb begin
    scanning  = (state == ST_SCAN);
    need_bit  = scanning && slot_open && !mode_extract && !done;
    in_ready  = (state == ST_IDLE);
    out_valid = (state == ST_SEND);
    wm_ready  = need_bit;
    take_bit  = need_bit && wm_valid;
    read_bit  = scanning && slot_open && mode_extract;
    advance   = scanning && (!need_bit || wm_valid);
    load      = in_ready && in_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      slot  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            state <= ST_SCAN;
            slot  <= '0;
          end
        end
        ST_SCAN: begin
          if (advance) begin
            if (slot == LAST_SLOT) state <= ST_SEND;
            else slot <= slot + 1'b1;
          end
        end
        ST_SEND: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wm_bit_counter.sv
module wm_bit_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/wm_cfg_marker.sv
module wm_cfg_marker
  import wm_pkg::*;
#(
  parameter int PAYLOAD_W = 8,
  parameter int COUNT_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_extract,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PAYLOAD_W-1:0] in_payload,
  input  logic [NUM_OUT-1:0]   in_used,
  input  logic [NUM_SLOT-1:0]  in_ctl,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PAYLOAD_W-1:0] out_payload,
  output logic [NUM_OUT-1:0]   out_used,
  output logic [NUM_SLOT-1:0]  out_ctl,
  input  logic                 wm_valid,
  output logic                 wm_ready,
  input  logic                 wm_bit,
  input  logic                 wm_last,
  output logic                 ext_valid,
  output logic                 ext_bit,
  output logic [COUNT_W-1:0]   bit_count,
  output logic                 wm_done
);

  logic [PAYLOAD_W-1:0] rec_payload;
  logic [NUM_OUT-1:0]   rec_used;
  logic [NUM_SLOT-1:0]  rec_ctl;
  logic [SLOT_W-1:0]    slot;
  logic [SLOT_W-1:0]    slot_pos;
  logic                 slot_open;
  logic                 take_bit;
  logic                 read_bit;
  logic                 load;

  wm_slot_decode u_decode (
    .used      (rec_used),
    .slot      (slot),
    .slot_open (slot_open),
    .slot_pos  (slot_pos)
  );

  wm_scan_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .out_ready    (out_ready),
    .slot_open    (slot_open),
    .mode_extract (mode_extract),
    .done         (wm_done),
    .wm_valid     (wm_valid),
    .slot         (slot),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .wm_ready     (wm_ready),
    .take_bit     (take_bit),
    .read_bit     (read_bit),
    .load         (load)
  );

  wm_bit_counter #(.WIDTH(COUNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .inc   (take_bit | read_bit),
    .count (bit_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_payload <= '0;
      rec_used    <= '0;
      rec_ctl     <= '0;
      wm_done     <= 1'b0;
      ext_valid   <= 1'b0;
      ext_bit     <= 1'b0;
    end else begin
      ext_valid <= read_bit;
      if (read_bit) ext_bit <= rec_ctl[slot_pos];
      if (load) begin
        rec_payload <= in_payload;
        rec_used    <= in_used;
        rec_ctl     <= in_ctl;
      end
      if (take_bit) begin
        rec_ctl[slot_pos] <= wm_bit;
        if (wm_last) wm_done <= 1'b1;
      end
    end
  end

  assign out_payload = rec_payload;
  assign out_used    = rec_used;
  assign out_ctl     = rec_ctl;

endmodule

// File: rtl/wm_cfg_marker_chk.sv
module wm_cfg_marker_chk #(
  parameter int PAYLOAD_W = 8,
  parameter int COUNT_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               mode_extract,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [11:0]        out_ctl,
  input logic               wm_valid,
  input logic               wm_ready,
  input logic               wm_last,
  input logic               ext_valid,
  input logic [COUNT_W-1:0] bit_count,
  input logic               wm_done
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !ext_valid && !wm_done && bit_count == '0));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ctl)));

  // R9
  no_dual_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R6
  done_blocks_source_chk: assert property (@(posedge clk) disable iff (rst)
    wm_done |-> !wm_ready);

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wm_done) |-> $past(wm_valid && wm_ready && wm_last));

  // R7
  extract_no_pull_chk: assert property (@(posedge clk) disable iff (rst)
    mode_extract |-> !wm_ready);

  // R7
  ext_only_in_extract_chk: assert property (@(posedge clk) disable iff (rst)
    ext_valid |-> mode_extract);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bit_count == $past(bit_count) || bit_count == $past(bit_count) + 1'b1));

endmodule

bind wm_cfg_marker wm_cfg_marker_chk #(
  .PAYLOAD_W (PAYLOAD_W),
  .COUNT_W   (COUNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_extract (mode_extract),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_ctl      (out_ctl),
  .wm_valid     (wm_valid),
  .wm_ready     (wm_ready),
  .wm_last      (wm_last),
  .ext_valid    (ext_valid),
  .bit_count    (bit_count),
  .wm_done      (wm_done)
);

// File: tb/sim_wm_cfg_marker.sv
`timescale 1ns/1ps
module sim_wm_cfg_marker;
  localparam int PW = 8;
  localparam int CW = 16;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, mode_extract;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [PW-1:0] in_payload, out_payload;
  logic [3:0] in_used, out_used;
  logic [11:0] in_ctl, out_ctl;
  logic wm_valid, wm_ready, wm_bit, wm_last;
  logic ext_valid, ext_bit, wm_done;
  logic [CW-1:0] bit_count;

  wm_cfg_marker #(.PAYLOAD_W(PW), .COUNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .mode_extract(mode_extract),
    .in_valid(in_valid), .in_ready(in_ready), .in_payload(in_payload),
    .in_used(in_used), .in_ctl(in_ctl),
    .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload),
    .out_used(out_used), .out_ctl(out_ctl),
    .wm_valid(wm_valid), .wm_ready(wm_ready), .wm_bit(wm_bit), .wm_last(wm_last),
    .ext_valid(ext_valid), .ext_bit(ext_bit), .bit_count(bit_count), .wm_done(wm_done)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit stream [256];
  int wm_len = 0, wm_ptr = 0;
  bit wm_en = 0, wm_thr = 0, o_stall = 0;
  logic [PW-1:0] rp [16];
  logic [3:0]    ru [16];
  logic [11:0]   rc [16];
  logic [11:0]   ec [16];
  logic [PW-1:0] gp [16];
  logic [3:0]    gu [16];
  logic [11:0]   gc [16];
  int n_got = 0;
  bit eb [128];
  int n_ext = 0;
  // fill order of R4: control bit position and owning output per slot
  int ord_pos [12] = '{0, 1, 2, 3, 4, 6, 5, 7, 8, 9, 11, 10};
  int ord_own [12] = '{0, 1, 2, 2, 2, 2, 2, 3, 3, 3, 3, 3};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (wm_valid && wm_ready) wm_ptr++;
    if (cyc > WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready && n_got < 16) begin
        gp[n_got] = out_payload;
        gu[n_got] = out_used;
        gc[n_got] = out_ctl;
        n_got++;
      end
      if (ext_valid && n_ext < 128) begin
        eb[n_ext] = ext_bit;
        n_ext++;
      end
    end
    out_ready = !(o_stall && (cyc % 4 == 1));
    wm_valid  = wm_en && (wm_ptr < wm_len) && (!wm_thr || (cyc % 3 == 0));
    wm_bit    = (wm_ptr < 256) ? stream[wm_ptr] : 1'b0;
    wm_last   = (wm_ptr == wm_len - 1);
  end

  task automatic do_reset(input bit ext);
    @(negedge clk);
    rst = 1'b1;
    mode_extract = ext;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    wm_ptr = 0;
    n_got = 0;
    n_ext = 0;
    rst = 1'b0;
  endtask

  task automatic send(input logic [PW-1:0] p, input logic [3:0] u, input logic [11:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_payload = p;
    in_used = u;
    in_ctl = c;
    do @(posedge clk); while (!in_ready);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(input int n);
    while (n_got < n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // bench model of embedding over records 0..n-1
  function automatic int model(input int n, input int len);
    int mp = 0;
    bit dn = 0;
    for (int r = 0; r < n; r++) begin
      ec[r] = rc[r];
      for (int k = 0; k < 12; k++) begin
        if (!ru[r][ord_own[k]] && !dn) begin
          ec[r][ord_pos[k]] = stream[mp];
          if (mp == len - 1) dn = 1;
          mp++;
        end
      end
    end
    return mp;
  endfunction

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int exp_bits;
    rst = 1'b1;
    mode_extract = 1'b0;
    in_valid = 1'b0;
    in_payload = '0;
    in_used = '0;
    in_ctl = '0;
    for (int i = 0; i < 256; i++) begin
      stream[i] = lfsr[0];
      lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    end

    // Phase A: embed, all usage patterns
    do_reset(1'b0);
    @(negedge clk);
    chk(in_ready && !out_valid && !ext_valid && !wm_done && bit_count == 0,
        "R1 reset state", {in_ready, out_valid, ext_valid, wm_done}, 4'b1000);
    wm_len = 200;
    wm_en = 1;
    for (int i = 0; i < 16; i++) begin
      rp[i] = PW'(i * 13 + 5);
      ru[i] = 4'(i);
      rc[i] = 12'hA5C ^ 12'(i * 12'h111);
    end
    exp_bits = model(16, 200);
    for (int i = 0; i < 16; i++) send(rp[i], ru[i], rc[i]);
    wait_out(16);
    for (int i = 0; i < 16; i++) begin
      chk(gc[i] == ec[i], "R4 R3 embedded controls", gc[i], ec[i]);
      chk(gp[i] == rp[i] && gu[i] == ru[i], "R2 payload and flags pass",
          {gp[i], gu[i]}, {rp[i], ru[i]});
    end
    chk(gc[15] == rc[15], "R2 fully used record untouched", gc[15], rc[15]);
    chk(exp_bits == 96 && bit_count == CW'(96), "R8 R3 embed count", bit_count, 96);
    chk(!wm_done, "R6 done stays low before last", wm_done, 0);

    // Phase B: extract from the marked records
    for (int i = 0; i < 16; i++) rc[i] = gc[i];
    wm_en = 0;
    do_reset(1'b1);
    for (int i = 0; i < 16; i++) send(rp[i], ru[i], rc[i]);
    wait_out(16);
    chk(n_ext == 96, "R7 extract pulse count", n_ext, 96);
    for (int i = 0; i < 96; i++)
      chk(eb[i] == stream[i], "R7 recovered bit", eb[i], stream[i]);
    for (int i = 0; i < 16; i++)
      chk(gc[i] == rc[i], "R7 record unchanged in extract", gc[i], rc[i]);
    chk(bit_count == CW'(96) && !wm_done, "R8 extract count", bit_count, 96);

    // Phase C: stalled source, end of watermark, throttled output
    do_reset(1'b0);
    wm_len = 17;
    wm_en = 0;
    wm_thr = 1;
    o_stall = 1;
    rp[0] = 8'h11; ru[0] = 4'b0000; rc[0] = 12'h000;
    rp[1] = 8'h22; ru[1] = 4'b0000; rc[1] = 12'hFFF;
    rp[2] = 8'h33; ru[2] = 4'b0101; rc[2] = 12'hA5A;
    void'(model(3, 17));
    send(rp[0], ru[0], rc[0]);
    repeat (30) @(negedge clk);
    chk(!out_valid, "R5 record held without bit", out_valid, 0);
    chk(!in_ready, "R5 R9 input blocked while held", in_ready, 0);
    wm_en = 1;
    send(rp[1], ru[1], rc[1]);
    send(rp[2], ru[2], rc[2]);
    wait_out(3);
    for (int i = 0; i < 3; i++)
      chk(gc[i] == ec[i], "R6 R5 controls around end", gc[i], ec[i]);
    chk(gc[1][11:7] == 5'b11111 && gc[2] == 12'hA5A, "R6 later fields unchanged",
        {gc[1][11:7], gc[2]}, {5'b11111, 12'hA5A});
    chk(wm_done && !wm_ready, "R6 done raised", {wm_done, wm_ready}, 2'b10);
    chk(bit_count == CW'(17) && wm_ptr == 17, "R8 count at end", bit_count, 17);
    finish_run();
  end

endmodule